// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters over a shared transfer clock. The least significant bit goes first. Software hands a character to a one-deep transmit buffer. The block copies the buffer into a shift register when that register is free and then shifts the character out on the transmit line. At the same time it shifts a character in from the receive line into a second shift register. When the last bit has been sampled, the received character lands in a one-deep receive buffer.

The block has two clock modes. In master mode it makes the transfer clock itself from the system clock through a programmable divider. It starts a new character only while transmit is enabled and the clear-to-send input is low. In slave mode it follows a clock that arrives from outside. That clock is first re-timed into the system clock domain. In slave mode the block drives a ready-to-send output that tells the far end when the receive buffer has room. Reception always rides on a transmission, so the receiver gets a character only after a character (dummy data if need be) has been written to the transmit buffer. The block gives three status flags: transmit buffer empty, receive complete and transmit shifter empty. It also pulses one interrupt request for each buffer move.

Top module: `syncSerialPort`

## Requirements
- R1: After reset, txBufEmpty=1, rxDone=0, txShiftEmpty=1, sclkOut=1, txd=1 and rts=0.
- R2: In master mode (intClk=1) each low half and each high half of sclkOut inside a character lasts divN+1 system clocks, so the full period is 2(divN+1). sclkOut rests high between characters.
- R3: Bits move least significant first. txd takes the next bit on each falling transfer-clock edge, and rxd is sampled on each rising edge. Eight rising edges make one character.
- R4: A write (wrTx) sets txBufEmpty to 0. When the buffer contents move into the shift register, txBufEmpty returns to 1 and irqTx pulses high for one cycle.
- R5: In master mode, while ctsN is high at a character boundary, no transfer starts. sclkOut stays high and txBufEmpty stays 0 until ctsN goes low.
- R6: With txEn=0 no transfer starts in either mode, and a written character stays in the buffer.
- R7: txShiftEmpty is 0 from the cycle after a transfer starts until the character is finished, and 1 otherwise.
- R8: With rxEn=1, on the eighth rising edge the assembled character appears on rxData, rxDone becomes 1 and irqRx pulses for one cycle. A read (rdRx) clears rxDone.
- R9: With rxEn=0 a finished transfer leaves rxDone at 0 and rxData unchanged.
- R10: In slave mode (intClk=0) shifting follows the edges of sclkIn after a two-flop synchronizer. The system clock must run at least 4 times faster than sclkIn.
- R11: In slave mode with rxEn=1, rts goes to 1 when a transfer starts. It stays 1 after the character is received, and it returns to 0 only when a read clears rxDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider count source |
| rstN | input | 1 | Active-low synchronous reset |
| intClk | input | 1 | 1 = master (internal transfer clock), 0 = slave |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| divN | input | DIV_W | Divider value n; transfer period is 2(n+1) clocks |
| wrTx | input | 1 | Write strobe for the transmit buffer |
| wrData | input | DATA_W | Character to write |
| rdRx | input | 1 | Read strobe for the receive buffer |
| rxData | output | DATA_W | Receive buffer contents |
| txBufEmpty | output | 1 | Transmit buffer empty flag |
| rxDone | output | 1 | Receive complete flag |
| txShiftEmpty | output | 1 | Transmit shifter idle flag |
| irqTx | output | 1 | One-cycle pulse on buffer-to-shifter move |
| irqRx | output | 1 | One-cycle pulse on shifter-to-buffer move |
| sclkIn | input | 1 | External transfer clock (slave mode) |
| sclkOut | output | 1 | Generated transfer clock (master mode) |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| ctsN | input | 1 | Clear to send, active low (master mode) |
| rts | output | 1 | Not-ready indication to the sender (slave mode) |

## Verification
The bench steps the divider through its smallest values and checks every half period of the generated clock. A divider that is off by one gives halves of n or n+2 cycles. In loopback it checks walking, all-zero, all-one and alternating characters. A design that shifts MSB first, or that samples on the wrong edge, gives back a mirrored or shifted character. It holds clear-to-send high and transmit enable low while a character waits. A design that ignores either one starts clocking early and sets the buffer flag back to 1. In slave mode it feeds a slow external clock and checks that rts stays high after reception and drops only when the buffer is read. A design that lowers rts when reception finishes fails that check.

// File: rtl/syncSerialPkg.sv
package syncSerialPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_TAIL  = 3'd4
  } xferState_t;

  typedef struct packed {
    logic load;
    logic fallEv;
    logic riseEv;
    logic lastEv;
  } sspStrobes_t;

endpackage

// File: rtl/sspControl.sv
module sspControl
  import syncSerialPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intClk,
  input  logic             txEn,
  input  logic             ctsN,
  input  logic             txBufEmpty,
  input  logic             sclkIn,
  input  logic [DIV_W-1:0] divN,
  output sspStrobes_t      strb,
  output logic             sclkOut,
  output logic             txShiftEmpty
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  xferState_t state, nextState;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0] syncQ;
  logic fallIn, riseIn, divHit;

  assign fallIn = syncQ[2] & ~syncQ[1];
  assign riseIn = ~syncQ[2] & syncQ[1];
  assign divHit = (divCnt == divN);
  assign txShiftEmpty = (state == ST_IDLE);

  always_comb begin
    strb = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (!txBufEmpty && txEn && (!intClk || !ctsN)) begin
          strb.load = 1'b1;
          nextState = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (intClk || fallIn) begin
          strb.fallEv = 1'b1;
          nextState = ST_LOW;
        end
      end
      ST_LOW: begin
        if (intClk ? divHit : riseIn) begin
          strb.riseEv = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strb.lastEv = 1'b1;
            nextState = intClk ? ST_TAIL : ST_IDLE;
          end else begin
            nextState = ST_HIGH;
          end
        end
      end
      ST_HIGH: begin
        if (intClk ? divHit : fallIn) begin
          strb.fallEv = 1'b1;
          nextState = ST_LOW;
        end
      end
      ST_TAIL: begin
        if (divHit) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      syncQ   <= 3'b111;
      sclkOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[1:0], sclkIn};
      state <= nextState;
      if (nextState != state) divCnt <= '0;
      else                    divCnt <= divCnt + 1'b1;
      if (strb.load)        bitCnt <= '0;
      else if (strb.riseEv) bitCnt <= bitCnt + 1'b1;
      if (strb.fallEv && intClk)       sclkOut <= 1'b0;
      else if (strb.riseEv || !intClk) sclkOut <= 1'b1;
    end
  end

endmodule

// File: rtl/sspDatapath.sv
module sspDatapath
  import syncSerialPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobes_t       strb,
  input  logic              intClk,
  input  logic              rxEn,
  input  logic              wrTx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdRx,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              txBufEmpty,
  output logic              rxDone,
  output logic              irqTx,
  output logic              irqRx,
  output logic              txd,
  output logic              rts
);
  logic [DATA_W-1:0] txBuf, shOut, shIn, shInNext;

  assign shInNext = {rxd, shIn[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf      <= '0;
      txBufEmpty <= 1'b1;
      shOut      <= '0;
      shIn       <= '0;
      rxData     <= '0;
      rxDone     <= 1'b0;
      irqTx      <= 1'b0;
      irqRx      <= 1'b0;
      txd        <= 1'b1;
      rts        <= 1'b0;
    end else begin
      irqTx <= strb.load;
      irqRx <= strb.lastEv && rxEn;

      if (wrTx) begin
        txBuf      <= wrData;
        txBufEmpty <= 1'b0;
      end else if (strb.load) begin
        txBufEmpty <= 1'b1;
      end

      if (strb.load) shOut <= txBuf;
      else if (strb.fallEv) begin
        txd   <= shOut[0];
        shOut <= shOut >> 1;
      end

      if (strb.riseEv) shIn <= shInNext;

      if (strb.lastEv && rxEn) begin
        rxData <= shInNext;
        rxDone <= 1'b1;
      end else if (rdRx && rxDone) begin
        rxDone <= 1'b0;
      end

      if (strb.load && !intClk && rxEn) rts <= 1'b1;
      else if (rdRx && rxDone && !(strb.lastEv && rxEn)) rts <= 1'b0;
    end
  end

endmodule

// File: rtl/syncSerialPort.sv
module syncSerialPort
  import syncSerialPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intClk,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic [DIV_W-1:0]  divN,
  input  logic              wrTx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdRx,
  output logic [DATA_W-1:0] rxData,
  output logic              txBufEmpty,
  output logic              rxDone,
  output logic              txShiftEmpty,
  output logic              irqTx,
  output logic              irqRx,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              txd,
  input  logic              rxd,
  input  logic              ctsN,
  output logic              rts
);
  sspStrobes_t strb;

  sspControl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .intClk(intClk), .txEn(txEn), .ctsN(ctsN),
    .txBufEmpty(txBufEmpty), .sclkIn(sclkIn), .divN(divN), .strb(strb),
    .sclkOut(sclkOut), .txShiftEmpty(txShiftEmpty)
  );

  sspDatapath #(.DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .intClk(intClk), .rxEn(rxEn),
    .wrTx(wrTx), .wrData(wrData), .rdRx(rdRx), .rxd(rxd), .rxData(rxData),
    .txBufEmpty(txBufEmpty), .rxDone(rxDone), .irqTx(irqTx), .irqRx(irqRx),
    .txd(txd), .rts(rts)
  );

endmodule

// File: rtl/sspChecker.sv
module sspChecker (
  input logic clk,
  input logic rstN,
  input logic intClk,
  input logic rxEn,
  input logic ctsN,
  input logic wrTx,
  input logic rdRx,
  input logic txBufEmpty,
  input logic rxDone,
  input logic txShiftEmpty,
  input logic irqTx,
  input logic irqRx,
  input logic sclkOut,
  input logic rts
);
  // R4
  tiClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBufEmpty) |-> $past(wrTx));
  // R4
  irqTxBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTx |-> !txShiftEmpty);
  // R2
  idleClkHigh_chk: assert property (@(posedge clk) disable iff (!rstN)
    txShiftEmpty |-> sclkOut);
  // R5
  ctsHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txShiftEmpty) && $past(intClk) && $past(ctsN)) |-> txShiftEmpty);
  // R9
  riNeedsRx_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(rxEn));
  // R8
  irqRxFlag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqRx |-> rxDone);
  // R11
  rtsLow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rts) |-> $past(rdRx && rxDone));
endmodule

bind syncSerialPort sspChecker i_sspChecker (
  .clk(clk), .rstN(rstN), .intClk(intClk), .rxEn(rxEn), .ctsN(ctsN),
  .wrTx(wrTx), .rdRx(rdRx), .txBufEmpty(txBufEmpty), .rxDone(rxDone),
  .txShiftEmpty(txShiftEmpty), .irqTx(irqTx), .irqRx(irqRx),
  .sclkOut(sclkOut), .rts(rts)
);

// File: tb/test_syncSerialPort.sv
module test_syncSerialPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intClk = 1'b1, txEn = 1'b1, rxEn = 1'b1;
  logic [7:0] divN = 8'd0;
  logic wrTx = 1'b0, rdRx = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rxData;
  logic txBufEmpty, rxDone, txShiftEmpty, irqTx, irqRx;
  logic sclkIn = 1'b1, sclkOut, txd, rxd, ctsN = 1'b0, rts;
  logic loopBack = 1'b1, rxdDrv = 1'b1;
  int checks = 0, fails = 0;
  bit finished = 0;

  assign rxd = loopBack ? txd : rxdDrv;
  always #10 clk = ~clk;

  syncSerialPort i_syncSerialPort (
    .clk(clk), .rstN(rstN), .intClk(intClk), .txEn(txEn), .rxEn(rxEn),
    .divN(divN), .wrTx(wrTx), .wrData(wrData), .rdRx(rdRx), .rxData(rxData),
    .txBufEmpty(txBufEmpty), .rxDone(rxDone), .txShiftEmpty(txShiftEmpty),
    .irqTx(irqTx), .irqRx(irqRx), .sclkIn(sclkIn), .sclkOut(sclkOut),
    .txd(txd), .rxd(rxd), .ctsN(ctsN), .rts(rts)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeTx(input logic [7:0] d);
    @(negedge clk); wrTx = 1'b1; wrData = d;
    @(negedge clk); wrTx = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk); rdRx = 1'b1;
    @(negedge clk); rdRx = 1'b0;
  endtask

  // Observe one master character: half periods, bits on txd at rising edges, irq pulses
  task automatic watchMaster(input int n, input logic [7:0] txExp, input bit expRx,
                             input logic [7:0] rxExp);
    logic prev = 1'b1;
    int since = 0, halves = 0, badHalves = 0, rises = 0, irqT = 0, irqR = 0;
    bit sawBusy = 0, started = 0;
    logic [7:0] seen = 8'd0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (irqTx) irqT++;
      if (irqRx) irqR++;
      if (!txShiftEmpty) sawBusy = 1;
      if (sclkOut != prev) begin
        if (started) begin
          halves++;
          if (since != n + 1) badHalves++;
        end
        started = 1;
        since = 0;
        if (sclkOut) begin
          if (rises < 8) seen[rises] = txd;
          rises++;
        end
      end
      since++;
      prev = sclkOut;
      if (sawBusy && txShiftEmpty) break;
    end
    check(halves == 15 && badHalves == 0, "R2 half period count/len", halves*100+badHalves, 1500);
    check(seen == txExp, "R3 txd bits lsb first", seen, txExp);
    check(rises == 8, "R3 rising edges per character", rises, 8);
    check(irqT == 1 && txBufEmpty, "R4 irqTx pulse and buffer empty", irqT, 1);
    check(txShiftEmpty && sclkOut, "R7 shifter idle, clock high", txShiftEmpty, 1);
    if (expRx) begin
      check(rxDone && irqR == 1, "R8 rxDone and irqRx", rxDone*10+irqR, 11);
      check(rxData == rxExp, "R8 received character", rxData, rxExp);
    end else begin
      check(!rxDone && irqR == 0, "R9 no rxDone when rxEn=0", rxDone, 0);
      check(rxData == rxExp, "R9 rxData unchanged", rxData, rxExp);
    end
  endtask

  task automatic slaveXfer(input logic [7:0] txB, input logic [7:0] rxB);
    logic [7:0] seen = 8'd0;
    writeTx(txB);
    repeat (3) @(negedge clk);
    check(rts == 1'b1, "R11 rts high at transfer start", rts, 1);
    check(!txShiftEmpty, "R7 shifter busy in slave", txShiftEmpty, 0);
    for (int b = 0; b < 8; b++) begin
      sclkIn = 1'b0; rxdDrv = rxB[b];
      repeat (6) @(negedge clk);
      seen[b] = txd;
      sclkIn = 1'b1;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(seen == txB, "R10 slave txd bits", seen, txB);
    check(rxDone && rxData == rxB, "R10 slave received character", rxData, rxB);
    check(txShiftEmpty, "R7 shifter idle after slave char", txShiftEmpty, 1);
    check(rts == 1'b1, "R11 rts stays high after reception", rts, 1);
    readRx();
    check(rts == 1'b0 && !rxDone, "R11 rts low after read", rts*10+rxDone, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
    logic [7:0] lastRx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(txBufEmpty && !rxDone && txShiftEmpty && sclkOut && txd && !rts,
          "R1 reset state", {txBufEmpty, rxDone, txShiftEmpty, sclkOut, txd, rts}, 6'b101110);

    // R2 R3 R8: divider sweep with loopback
    for (int n = 0; n < 4; n++) begin
      for (int p = 0; p < 6; p++) begin
        logic [7:0] d = pats[p] ^ 8'(n * 17);
        divN = 8'(n);
        writeTx(d);
        watchMaster(n, d, 1, d);
        readRx();
        check(!rxDone, "R8 read clears rxDone", rxDone, 0);
      end
    end
    lastRx = rxData;

    // R5: CTS high holds the character
    ctsN = 1'b1; divN = 8'd2;
    writeTx(8'h5A);
    check(!txBufEmpty, "R4 write clears txBufEmpty", txBufEmpty, 0);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (!sclkOut || txBufEmpty || !txShiftEmpty) begin
        check(0, "R5 cts high holds transfer", sclkOut, 1);
        break;
      end
    end
    check(!txBufEmpty && txShiftEmpty && sclkOut, "R5 still waiting", txBufEmpty, 0);
    ctsN = 1'b0;
    watchMaster(2, 8'h5A, 1, 8'h5A);
    readRx();

    // R6: txEn low holds the character
    txEn = 1'b0;
    writeTx(8'hC3);
    repeat (30) @(negedge clk);
    check(!txBufEmpty && txShiftEmpty && sclkOut, "R6 txEn=0 holds transfer", txBufEmpty, 0);
    txEn = 1'b1;
    watchMaster(2, 8'hC3, 1, 8'hC3);
    readRx();
    lastRx = rxData;

    // R9: rxEn low
    rxEn = 1'b0; divN = 8'd1;
    writeTx(8'h96);
    watchMaster(1, 8'h96, 0, lastRx);
    rxEn = 1'b1;

    // R10 R11: slave mode
    intClk = 1'b0; loopBack = 1'b0;
    @(negedge clk);
    check(sclkOut == 1'b1, "R2 clock high in slave mode", sclkOut, 1);
    slaveXfer(8'h6D, 8'hB2);
    slaveXfer(8'hFF, 8'h01);
    slaveXfer(8'h80, 8'h7E);

    // R6 in slave mode: no transfer with txEn low
    txEn = 1'b0;
    writeTx(8'h11);
    repeat (4) @(negedge clk);
    check(txShiftEmpty && !txBufEmpty && !rts, "R6 slave txEn=0 no start", txShiftEmpty, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule